// File: doc/BRIEF.md
# Host-to-target bridge register bank

This register bank connects a host bus to a target processor on a development card. The host sees a small set of 32-bit word registers. Through them it passes a 6-bit mailbox value down to the target and sends reset and non-maskable-interrupt pulses. It can also read two 6-bit mailboxes that the target fills. One of these target-to-host mailboxes raises a host interrupt when written. The other is silent and is meant for polling.

A separate 1 MB region of the host address space is a window onto a 16 MB target memory. A 4-bit page register chooses which 1 MB page the window reaches. Window accesses leave the block as a memory request, and the address is the page select placed above the low 20 offset bits.

The host port and the target port are simple synchronous request ports that share one clock. Register read data is returned in the cycle after the read request. Window read data passes through from the memory, which answers one cycle after the request.

Top module: `hbridge_regbank`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, all outputs are zero. This covers the interrupt, both pulses, the memory request and both read-data buses.
- R2: In the cycle after a host read of offset 0x000, `h_rdata_o` holds the parameter `PROD_ID` in bits 7:0 and zero in all higher bits.
- R3: A host write to offset 0x400 with bit 1 set makes `tgt_rst_o` high for exactly the next cycle. The same write with bit 2 set does the same for `tgt_nmi_o`. All other bits are ignored, and a host read of 0x400 returns zero.
- R4: A host write to 0x800 stores `h_wdata_i[5:0]`. A later host read of 0x800 returns it in bits 5:0. A target read of address 0x18000800 returns it on `t_rdata_o` in the next cycle.
- R5: A host write to 0xA00 stores `h_wdata_i[23:20]` as the page select. A host read of 0xA00 returns it in bits 23:20 with all other bits zero. No other access changes it.
- R6: A host access with offset bit 20 set (0x100000 to 0x1FFFFC) drives `mem_req_o` in the same cycle. It also drives `mem_we_o`, `mem_wdata_o`, and `mem_addr_o` = {page select, offset[19:0]}. For a read, `h_rdata_o` in the next cycle equals `mem_rdata_i`.
- R7: A target write to 0x18000000 stores `t_wdata_i` in the register read by the host at 0xC00 and sets `host_irq_o` from the next cycle.
- R8: A target write to 0x18000400 stores `t_wdata_i` in the register read by the host at 0xE00 and does not raise `host_irq_o`.
- R9: `host_irq_o` stays high until a host read of 0xC00 and is low from the cycle after that read. If a target write to 0x18000000 happens in the same cycle as the read, the interrupt stays high, and the read returns the value held before the write.
- R10: Host reads of unmapped offsets return zero. Target reads of any address other than 0x18000800 return zero. Host writes to 0x000, 0xC00 and 0xE00 do not change what those offsets read back. Read-data outputs are zero in cycles that follow no read.
- R11: Reset and NMI pulses sent to the target do not clear the mailboxes or the page select. Only `rst_ni` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_req_i | input | 1 | Host access request |
| h_we_i | input | 1 | Host write (1) or read (0) |
| h_addr_i | input | 21 | Host byte offset |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data, cycle after request |
| t_req_i | input | 1 | Target access request |
| t_we_i | input | 1 | Target write (1) or read (0) |
| t_addr_i | input | 32 | Target address |
| t_wdata_i | input | 6 | Target write data |
| t_rdata_o | output | 6 | Target read data, cycle after request |
| mem_req_o | output | 1 | Window memory request |
| mem_we_o | output | 1 | Window memory write |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, cycle after request |
| host_irq_o | output | 1 | Host interrupt |
| tgt_rst_o | output | 1 | Target master reset pulse |
| tgt_nmi_o | output | 1 | Target NMI pulse |

## Verification
The bench builds the block with `PROD_ID` set to 8'hC3 and every width at its default. With the 4-bit page select, every page from 0x0 to 0xF can be reached, and the two window edges, 0x100000 and 0x1FFFFC, sit at the ends of a page. The identifier override separates the identifier bits from a default-valued constant. The 6-bit mailboxes allow all-ones and alternating patterns, which expose masking of the upper write-data bits.

// File: rtl/hbridge_pkg.sv
`timescale 1ns/1ps
package hbridge_pkg;
  localparam logic [11:0] OFF_ID   = 12'h000;
  localparam logic [11:0] OFF_CTRL = 12'h400;
  localparam logic [11:0] OFF_DOWN = 12'h800;
  localparam logic [11:0] OFF_PAGE = 12'hA00;
  localparam logic [11:0] OFF_UPI  = 12'hC00;
  localparam logic [11:0] OFF_UPS  = 12'hE00;
  localparam int BIT_RST = 1;
  localparam int BIT_NMI = 2;
  localparam logic [31:0] TGT_UPI  = 32'h1800_0000;
  localparam logic [31:0] TGT_UPS  = 32'h1800_0400;
  localparam logic [31:0] TGT_DOWN = 32'h1800_0800;
endpackage

// File: rtl/hb_host_regs.sv
`timescale 1ns/1ps
module hb_host_regs import hbridge_pkg::*; #(
  parameter int HADDR_W  = 21,
  parameter int DATA_W   = 32,
  parameter int MBOX_W   = 6,
  parameter int PAGE_W   = 4,
  parameter int PAGE_LSB = 20,
  parameter int ID_W     = 8,
  parameter logic [ID_W-1:0] PROD_ID = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               win_hit_i,
  input  logic [MBOX_W-1:0]  mb_int_i,
  input  logic [MBOX_W-1:0]  mb_sync_i,
  output logic [MBOX_W-1:0]  mbox_dn_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic               rst_pulse_o,
  output logic               nmi_pulse_o,
  output logic               rd_int_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rd_mem_o
);
  logic wr, rd, wr_ctrl, wr_down, wr_page;
  logic [DATA_W-1:0] rd_val;
  logic unused_wd;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctrl = wr & (addr_i == HADDR_W'(OFF_CTRL));
  assign wr_down = wr & (addr_i == HADDR_W'(OFF_DOWN));
  assign wr_page = wr & (addr_i == HADDR_W'(OFF_PAGE));
  assign rd_int_o = rd & (addr_i == HADDR_W'(OFF_UPI));
  assign unused_wd = ^wdata_i;

  always_comb begin
    rd_val = '0;
    if (addr_i == HADDR_W'(OFF_ID))   rd_val[ID_W-1:0]          = PROD_ID;
    if (addr_i == HADDR_W'(OFF_DOWN)) rd_val[MBOX_W-1:0]        = mbox_dn_o;
    if (addr_i == HADDR_W'(OFF_PAGE)) rd_val[PAGE_LSB +: PAGE_W] = page_o;
    if (addr_i == HADDR_W'(OFF_UPI))  rd_val[MBOX_W-1:0]        = mb_int_i;
    if (addr_i == HADDR_W'(OFF_UPS))  rd_val[MBOX_W-1:0]        = mb_sync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbox_dn_o   <= '0;
      page_o      <= '0;
      rst_pulse_o <= 1'b0;
      nmi_pulse_o <= 1'b0;
      rdata_o     <= '0;
      rd_mem_o    <= 1'b0;
    end else begin
      rst_pulse_o <= wr_ctrl & wdata_i[BIT_RST];
      nmi_pulse_o <= wr_ctrl & wdata_i[BIT_NMI];
      if (wr_down) mbox_dn_o <= wdata_i[MBOX_W-1:0];
      if (wr_page) page_o    <= wdata_i[PAGE_LSB +: PAGE_W];
      rd_mem_o <= rd & win_hit_i;
      rdata_o  <= (rd && !win_hit_i) ? rd_val : '0;
    end
  end

  // R3: a pulse only follows a control write with its bit set
  a_r3_rst_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> $past(req_i && we_i && addr_i == HADDR_W'(OFF_CTRL) && wdata_i[BIT_RST]));
  a_r3_nmi_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pulse_o |-> $past(req_i && we_i && addr_i == HADDR_W'(OFF_CTRL) && wdata_i[BIT_NMI]));
  // R5, R11: page changes only on a page write
  a_r5_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_page |=> $stable(page_o));
  a_r11_down_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_down |=> $stable(mbox_dn_o));
endmodule

// File: rtl/hb_tgt_port.sv
`timescale 1ns/1ps
module hb_tgt_port import hbridge_pkg::*; #(
  parameter int TADDR_W = 32,
  parameter int MBOX_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [TADDR_W-1:0] addr_i,
  input  logic [MBOX_W-1:0]  wdata_i,
  input  logic [MBOX_W-1:0]  mbox_dn_i,
  input  logic               rd_int_i,
  output logic [MBOX_W-1:0]  mb_int_o,
  output logic [MBOX_W-1:0]  mb_sync_o,
  output logic               irq_o,
  output logic [MBOX_W-1:0]  rdata_o
);
  logic wr_int, wr_sync, rd_down;

  assign wr_int  = req_i & we_i  & (addr_i == TADDR_W'(TGT_UPI));
  assign wr_sync = req_i & we_i  & (addr_i == TADDR_W'(TGT_UPS));
  assign rd_down = req_i & ~we_i & (addr_i == TADDR_W'(TGT_DOWN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mb_int_o  <= '0;
      mb_sync_o <= '0;
      irq_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      if (wr_int)  mb_int_o  <= wdata_i;
      if (wr_sync) mb_sync_o <= wdata_i;
      // a new post wins over the clearing read
      if (wr_int)        irq_o <= 1'b1;
      else if (rd_int_i) irq_o <= 1'b0;
      rdata_o <= rd_down ? mbox_dn_i : '0;
    end
  end

  a_r7_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_int |=> irq_o);
  a_r8_sync_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && wr_sync) |=> !irq_o);
  a_r9_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_int_i) |=> irq_o);
  a_r4_tgt_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_down |=> (rdata_o == $past(mbox_dn_i)));
endmodule

// File: rtl/hb_mem_window.sv
`timescale 1ns/1ps
module hb_mem_window #(
  parameter int HADDR_W = 21,
  parameter int WIN_W   = 20,
  parameter int PAGE_W  = 4,
  parameter int DATA_W  = 32,
  localparam int MADDR_W = PAGE_W + WIN_W
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [PAGE_W-1:0]  page_i,
  output logic               hit_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o
);
  assign hit_o       = addr_i[HADDR_W-1:WIN_W] == (HADDR_W-WIN_W)'(1);
  assign mem_req_o   = req_i & hit_o;
  assign mem_we_o    = mem_req_o & we_i;
  assign mem_addr_o  = {page_i, addr_i[WIN_W-1:0]};
  assign mem_wdata_o = wdata_i;
endmodule

// File: rtl/hbridge_regbank.sv
`timescale 1ns/1ps
module hbridge_regbank #(
  parameter int HADDR_W = 21,
  parameter int TADDR_W = 32,
  parameter int DATA_W  = 32,
  parameter int MBOX_W  = 6,
  parameter int PAGE_W  = 4,
  parameter int WIN_W   = 20,
  parameter int ID_W    = 8,
  parameter logic [ID_W-1:0] PROD_ID = 8'h5A,
  localparam int MADDR_W = PAGE_W + WIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               h_req_i,
  input  logic               h_we_i,
  input  logic [HADDR_W-1:0] h_addr_i,
  input  logic [DATA_W-1:0]  h_wdata_i,
  output logic [DATA_W-1:0]  h_rdata_o,
  input  logic               t_req_i,
  input  logic               t_we_i,
  input  logic [TADDR_W-1:0] t_addr_i,
  input  logic [MBOX_W-1:0]  t_wdata_i,
  output logic [MBOX_W-1:0]  t_rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               host_irq_o,
  output logic               tgt_rst_o,
  output logic               tgt_nmi_o
);
  logic              win_hit, rd_int, rd_mem_q;
  logic [MBOX_W-1:0] mbox_dn, mb_int, mb_sync;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] reg_rdata;

  hb_mem_window #(.HADDR_W(HADDR_W), .WIN_W(WIN_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_win (
    .req_i(h_req_i), .we_i(h_we_i), .addr_i(h_addr_i), .wdata_i(h_wdata_i), .page_i(page),
    .hit_o(win_hit), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  hb_host_regs #(.HADDR_W(HADDR_W), .DATA_W(DATA_W), .MBOX_W(MBOX_W), .PAGE_W(PAGE_W),
                 .PAGE_LSB(WIN_W), .ID_W(ID_W), .PROD_ID(PROD_ID)) u_host (
    .clk_i, .rst_ni, .req_i(h_req_i), .we_i(h_we_i), .addr_i(h_addr_i), .wdata_i(h_wdata_i),
    .win_hit_i(win_hit), .mb_int_i(mb_int), .mb_sync_i(mb_sync),
    .mbox_dn_o(mbox_dn), .page_o(page), .rst_pulse_o(tgt_rst_o), .nmi_pulse_o(tgt_nmi_o),
    .rd_int_o(rd_int), .rdata_o(reg_rdata), .rd_mem_o(rd_mem_q));

  hb_tgt_port #(.TADDR_W(TADDR_W), .MBOX_W(MBOX_W)) u_tgt (
    .clk_i, .rst_ni, .req_i(t_req_i), .we_i(t_we_i), .addr_i(t_addr_i), .wdata_i(t_wdata_i),
    .mbox_dn_i(mbox_dn), .rd_int_i(rd_int), .mb_int_o(mb_int), .mb_sync_o(mb_sync),
    .irq_o(host_irq_o), .rdata_o(t_rdata_o));

  assign h_rdata_o = rd_mem_q ? mem_rdata_i : reg_rdata;

  // R6: window address carries the stored page
  a_r6_page_in_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[MADDR_W-1:WIN_W] == page));
endmodule

// File: tb/tb_hbridge_regbank.sv
`timescale 1ns/1ps
module tb_hbridge_regbank;
  localparam logic [7:0] PID = 8'hC3;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic h_req = 0, h_we = 0, t_req = 0, t_we = 0;
  logic [20:0] h_addr = '0;
  logic [31:0] h_wdata = '0, t_addr = '0, mem_rdata = '0, h_rdata, mem_wdata;
  logic [5:0] t_wdata = '0, t_rdata;
  logic mem_req, mem_we, host_irq, tgt_rst, tgt_nmi;
  logic [23:0] mem_addr;
  int checks = 0, fails = 0;
  bit ready = 0, done = 0;

  always #2.5 clk = ~clk;

  hbridge_regbank #(.PROD_ID(PID)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .h_req_i(h_req), .h_we_i(h_we), .h_addr_i(h_addr),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata), .t_req_i(t_req), .t_we_i(t_we),
    .t_addr_i(t_addr), .t_wdata_i(t_wdata), .t_rdata_o(t_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .host_irq_o(host_irq), .tgt_rst_o(tgt_rst), .tgt_nmi_o(tgt_nmi));

  // bench memory: answers one cycle later with a tag of the address
  always @(posedge clk) mem_rdata <= mem_req ? {8'hD0, mem_addr} : 32'h0;

  // reference model
  logic [5:0] m_dn, m_int, m_sync, e_tr;
  logic [3:0] m_pg;
  logic e_irq, e_rst, e_nmi;
  logic [31:0] e_hr;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dn <= 0; m_int <= 0; m_sync <= 0; m_pg <= 0; e_irq <= 0;
      e_rst <= 0; e_nmi <= 0; e_hr <= 0; e_tr <= 0;
    end else begin
      e_rst <= h_req && h_we && h_addr == 21'h400 && h_wdata[1];
      e_nmi <= h_req && h_we && h_addr == 21'h400 && h_wdata[2];
      if (h_req && h_we && h_addr == 21'h800) m_dn <= h_wdata[5:0];
      if (h_req && h_we && h_addr == 21'hA00) m_pg <= h_wdata[23:20];
      e_hr <= 0;
      if (h_req && !h_we) begin
        if (h_addr[20]) e_hr <= {8'hD0, m_pg, h_addr[19:0]};
        else case (h_addr)
          21'h000: e_hr <= {24'h0, PID};
          21'h800: e_hr <= {26'h0, m_dn};
          21'hA00: e_hr <= {8'h0, m_pg, 20'h0};
          21'hC00: e_hr <= {26'h0, m_int};
          21'hE00: e_hr <= {26'h0, m_sync};
          default: e_hr <= 0;
        endcase
      end
      if (t_req && t_we && t_addr == 32'h1800_0000) begin
        m_int <= t_wdata; e_irq <= 1;
      end else if (h_req && !h_we && h_addr == 21'hC00) e_irq <= 0;
      if (t_req && t_we && t_addr == 32'h1800_0400) m_sync <= t_wdata;
      e_tr <= (t_req && !t_we && t_addr == 32'h1800_0800) ? m_dn : 6'h0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) if (ready && rst_ni) begin
    chk(tgt_rst == e_rst, "R3 rst pulse", 32'(tgt_rst), 32'(e_rst));
    chk(tgt_nmi == e_nmi, "R3 nmi pulse", 32'(tgt_nmi), 32'(e_nmi));
    chk(host_irq == e_irq, "R7 R9 irq", 32'(host_irq), 32'(e_irq));
    chk(h_rdata == e_hr, "R2 R4 R5 R6 R10 host rdata", h_rdata, e_hr);
    chk(t_rdata == e_tr, "R4 R10 tgt rdata", 32'(t_rdata), 32'(e_tr));
    chk(mem_req == (h_req && h_addr[20]), "R6 mem_req", 32'(mem_req), 32'(h_req && h_addr[20]));
    if (h_req && h_addr[20]) begin
      chk(mem_addr == {m_pg, h_addr[19:0]}, "R6 mem_addr", 32'(mem_addr), 32'({m_pg, h_addr[19:0]}));
      chk(mem_we == h_we, "R6 mem_we", 32'(mem_we), 32'(h_we));
      if (h_we) chk(mem_wdata == h_wdata, "R6 mem_wdata", mem_wdata, h_wdata);
    end
  end

  task automatic idle();
    @(posedge clk); #1; h_req = 0; h_we = 0; t_req = 0; t_we = 0;
  endtask
  task automatic hwr(input logic [20:0] a, input logic [31:0] d);
    @(posedge clk); #1; h_req = 1; h_we = 1; h_addr = a; h_wdata = d; t_req = 0;
  endtask
  task automatic hrd(input logic [20:0] a);
    @(posedge clk); #1; h_req = 1; h_we = 0; h_addr = a; t_req = 0;
  endtask
  task automatic twr(input logic [31:0] a, input logic [5:0] d);
    @(posedge clk); #1; t_req = 1; t_we = 1; t_addr = a; t_wdata = d; h_req = 0;
  endtask
  task automatic trd(input logic [31:0] a);
    @(posedge clk); #1; t_req = 1; t_we = 0; t_addr = a; h_req = 0;
  endtask
  task automatic hrd_chk(input logic [20:0] a, input logic [31:0] exp, input string tag);
    hrd(a); idle(); @(negedge clk); chk(h_rdata == exp, tag, h_rdata, exp);
  endtask
  task automatic trd_chk(input logic [31:0] a, input logic [5:0] exp, input string tag);
    trd(a); idle(); @(negedge clk); chk(t_rdata == exp, tag, 32'(t_rdata), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..: run hung act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk({host_irq, tgt_rst, tgt_nmi, mem_req} == 0 && h_rdata == 0 && t_rdata == 0,
        "R1 outputs in reset", {host_irq, tgt_rst, tgt_nmi, mem_req}, 0);
    @(posedge clk); #1; rst_ni = 1;
    @(negedge clk);
    chk({host_irq, tgt_rst, tgt_nmi} == 0 && h_rdata == 0 && t_rdata == 0,
        "R1 outputs after reset", {host_irq, tgt_rst, tgt_nmi}, 0);
    ready = 1;

    hrd_chk(21'h000, {24'h0, PID}, "R2 product id");
    hwr(21'h800, 32'hFFFF_FFEA); idle();
    hrd_chk(21'h800, 32'h2A, "R4 host mailbox readback");
    trd_chk(32'h1800_0800, 6'h2A, "R4 target reads host mailbox");

    hwr(21'h400, 32'hFFFF_FFF9); idle(); @(negedge clk);
    chk(!tgt_rst && !tgt_nmi, "R3 other bits ignored", {tgt_rst, tgt_nmi}, 0);
    hwr(21'h400, 32'h2); idle(); @(negedge clk);
    chk(tgt_rst && !tgt_nmi, "R3 reset pulse", {tgt_rst, tgt_nmi}, 2);
    @(negedge clk); chk(!tgt_rst, "R3 reset one cycle", tgt_rst, 0);
    hwr(21'h400, 32'h4); idle(); @(negedge clk);
    chk(tgt_nmi && !tgt_rst, "R3 nmi pulse", {tgt_rst, tgt_nmi}, 1);
    @(negedge clk); chk(!tgt_nmi, "R3 nmi one cycle", tgt_nmi, 0);
    hrd_chk(21'h400, 0, "R3 control reads zero");

    hwr(21'h800, 32'h15); idle();
    hwr(21'h400, 32'h6); idle();
    hrd_chk(21'h800, 32'h15, "R11 mailbox survives target reset");

    hwr(21'hA00, 32'hFF5F_FFFF); idle();
    hrd_chk(21'hA00, 32'h0050_0000, "R5 page readback");
    hwr(21'h400, 32'h2); idle();
    hrd_chk(21'hA00, 32'h0050_0000, "R11 page survives target reset");
    hwr(21'h12_3454, 32'hCAFE_0001); @(negedge clk);
    chk(mem_req && mem_we && mem_addr == 24'h52_3454 && mem_wdata == 32'hCAFE_0001,
        "R6 window write", 32'(mem_addr), 32'h52_3454);
    idle();
    hwr(21'hA00, 32'h00F0_0000); idle();
    hrd_chk(21'h1F_FFFC, 32'hD0FF_FFFC, "R6 window top edge page F");
    hwr(21'hA00, 32'h0); idle();
    hrd_chk(21'h10_0000, 32'hD000_0000, "R6 window low edge page 0");
    hrd(21'h0F_FFFC); @(negedge clk);
    chk(!mem_req, "R10 below window no request", mem_req, 0);
    idle(); @(negedge clk); chk(h_rdata == 0, "R10 unmapped read zero", h_rdata, 0);

    twr(32'h1800_0000, 6'h15); idle(); @(negedge clk);
    chk(host_irq, "R7 irq raised", host_irq, 1);
    repeat (3) idle();
    @(negedge clk); chk(host_irq, "R9 irq held", host_irq, 1);
    hrd_chk(21'hC00, 32'h15, "R7 int mailbox value");
    chk(!host_irq, "R9 irq cleared by read", host_irq, 0);

    twr(32'h1800_0400, 6'h3C); idle(); @(negedge clk);
    chk(!host_irq, "R8 sync no irq", host_irq, 0);
    hrd_chk(21'hE00, 32'h3C, "R8 sync mailbox value");

    twr(32'h1800_0000, 6'h01); idle();
    @(posedge clk); #1; h_req = 1; h_we = 0; h_addr = 21'hC00;
    t_req = 1; t_we = 1; t_addr = 32'h1800_0000; t_wdata = 6'h07;
    idle(); @(negedge clk);
    chk(host_irq, "R9 write wins over clearing read", host_irq, 1);
    chk(h_rdata == 32'h01, "R9 read returns old value", h_rdata, 32'h01);
    hrd_chk(21'hC00, 32'h07, "R9 new value after collision");

    hwr(21'hC00, 32'h3F); idle();
    hwr(21'hE00, 32'h00); idle();
    hwr(21'h000, 32'h00); idle();
    hrd_chk(21'hC00, 32'h07, "R10 host write to int mailbox ignored");
    hrd_chk(21'hE00, 32'h3C, "R10 host write to sync mailbox ignored");
    hrd_chk(21'h000, {24'h0, PID}, "R10 id unchanged");
    hrd_chk(21'h004, 0, "R10 unmapped offset");
    trd_chk(32'h1800_0000, 0, "R10 target unmapped read");

    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [20:0] ha [8];
      logic [31:0] ta [4];
      ha = '{21'h000, 21'h400, 21'h800, 21'hA00, 21'hC00, 21'hE00, 21'h10_0040, 21'h1F_FFFC};
      ta = '{32'h1800_0000, 32'h1800_0400, 32'h1800_0800, 32'h1800_0C00};
      sel = $urandom % 8;
      @(posedge clk); #1;
      h_req = $urandom_range(0, 1); h_we = $urandom_range(0, 1);
      h_addr = ha[sel]; h_wdata = $urandom;
      t_req = $urandom_range(0, 1); t_we = $urandom_range(0, 1);
      t_addr = ta[$urandom % 4]; t_wdata = 6'($urandom);
    end
    idle(); idle(); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule